// File: doc/BRIEF.md
# Vertical blanking interrupt generator

This block derives the frame timing of a video controller from the CPU clock alone. A single counter splits every frame into an active-display phase and a blanking phase. While the blanking phase lasts, the block holds an active-low interrupt line low and raises a matching access flag. The access flag tells the rest of the chip that the CPU may reach the video registers and the graphics RAM and ROM. The blanking phase starts the moment the active picture is finished, when the solid bottom border begins. The frame length and the blanking length are parameters, with defaults of 14934 and 3791 CPU cycles.

The block also holds the CPU-side acceptance logic for that line. The line is a plain level, and nothing latches it. At each interruptible instruction boundary, the CPU samples it together with its interrupt enable flag. If the line is low and the flag is set, the block emits a one-cycle "interrupt taken" strobe. At most one strobe is issued per blanking window. If no qualified boundary falls inside the window, the request is lost and is never delivered afterwards.

The timer is a two-state machine. `PH_ACTIVE` moves to `PH_BLANK` when the active count is used up, and `PH_BLANK` moves back to `PH_ACTIVE` when the blanking count is used up. The acceptance logic is a three-state machine:
- `ACC_IDLE` (line high) moves to `ACC_OPEN` when the line goes low with no qualified boundary.
- `ACC_IDLE` moves to `ACC_HELD` when the line is low and a qualified boundary arrives in the same cycle.
- `ACC_OPEN` moves to `ACC_HELD` on a qualified boundary.
- `ACC_OPEN` moves back to `ACC_IDLE` when the window closes untaken, which is the dropped case.
- `ACC_HELD` moves back to `ACC_IDLE` when the line returns high.

Top module: `vblank_irq_gen`

## Requirements
- R1: `vblank_n` is active low. It is high during and right after reset, and once it falls it stays low without a gap for the whole assertion.
- R2: Successive falling edges of `vblank_n` are exactly FRAME_CYCLES clock edges apart (default 14934).
- R3: Each assertion of `vblank_n` lasts exactly BLANK_CYCLES clock cycles (default 3791).
- R4: The first assertion after reset begins FRAME_CYCLES − BLANK_CYCLES rising edges after reset is released (default 11143). This is the end of active display.
- R5: `blank_access` is 1 in exactly the cycles where `vblank_n` is 0, and 0 in all other cycles.
- R6: A rising edge is a qualified sample when `vblank_n`=0, `irq_en`=1 and `insn_boundary`=1 before that edge. `irq_taken` is 1 for exactly the one cycle that follows the first qualified sample of a window. This holds for a sample on the first cycle of the window and for one on its last cycle.
- R7: A window with `irq_en`=0 throughout, or with no `insn_boundary`, gives no `irq_taken`. No strobe appears later for it, because the request is not remembered.
- R8: At most one `irq_taken` pulse is produced per assertion window, however many qualified samples the window contains.
- R9: Synchronous reset (`rst`=1 at a rising edge) forces `vblank_n`=1, `blank_access`=0 and `irq_taken`=0, and restarts frame timing at the start of active display. This applies even in the middle of a window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_en | input | 1 | CPU interrupt enable flag |
| insn_boundary | input | 1 | High in a cycle where the CPU is at an interruptible instruction boundary |
| vblank_n | output | 1 | Vertical blanking interrupt line, active low |
| blank_access | output | 1 | High during the blanking interval, when graphics access is granted |
| irq_taken | output | 1 | One-cycle strobe: the interrupt was accepted |

## Verification
`vblank_n` and `blank_access` change on the same rising edge that ends a phase count. A phase of N cycles therefore shows as exactly N low or high samples. `irq_taken` appears in the cycle after the edge that sampled the qualified boundary, so a boundary on the last window cycle yields a strobe after the line has already returned high.

The bench drives inputs 1 ns after each rising edge and compares all three outputs with its behavioural model at every falling edge. It applies the same one-edge lag for the strobe. It also measures widths, spacing and the reset-to-first-assertion delay from the observed edges of `vblank_n`.

// File: rtl/vbl_pkg.sv
package vbl_pkg;

    // Frame phase of the blanking timer
    typedef enum logic {
        PH_ACTIVE = 1'b0,
        PH_BLANK  = 1'b1
    } frame_phase_t;

    // Acceptance state on the CPU side
    typedef enum logic [1:0] {
        ACC_IDLE = 2'd0,
        ACC_OPEN = 2'd1,
        ACC_HELD = 2'd2
    } accept_state_t;

endpackage

// File: rtl/vbl_frame_timer.sv
module vbl_frame_timer
    import vbl_pkg::*;
#(
    parameter int FRAME_CYCLES = 14934,
    parameter int BLANK_CYCLES = 3791
) (
    input  logic clk,
    input  logic rst,
    output logic blank
);
    localparam int ACTIVE_CYCLES = FRAME_CYCLES - BLANK_CYCLES;
    localparam int CW  = $clog2(FRAME_CYCLES);
    localparam int CKW = CW + 1;
    localparam logic [CW-1:0] ACT_LAST = CW'(ACTIVE_CYCLES - 1);
    localparam logic [CW-1:0] BLK_LAST = CW'(BLANK_CYCLES - 1);

    frame_phase_t    phase_q, phase_d;
    logic [CW-1:0]   cnt_q, cnt_d;

    // next-state logic
    always_comb begin
        phase_d = phase_q;
        cnt_d   = cnt_q + 1'b1;
        unique case (phase_q)
            PH_ACTIVE: begin
                if (cnt_q == ACT_LAST) begin
                    phase_d = PH_BLANK;
                    cnt_d   = '0;
                end
            end
            PH_BLANK: begin
                if (cnt_q == BLK_LAST) begin
                    phase_d = PH_ACTIVE;
                    cnt_d   = '0;
                end
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_ACTIVE;
            cnt_q   <= '0;
        end else begin
            phase_q <= phase_d;
            cnt_q   <= cnt_d;
        end
    end

    // outputs
    always_comb begin
        blank = (phase_q == PH_BLANK);
    end

    // ---------------- checks ----------------
    logic [CKW-1:0] chk_low_run;
    logic [CKW-1:0] chk_gap;
    logic           chk_blank_d;
    logic           chk_seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            chk_low_run <= '0;
            chk_gap     <= '0;
            chk_blank_d <= 1'b0;
            chk_seen    <= 1'b0;
        end else begin
            chk_low_run <= blank ? chk_low_run + 1'b1 : '0;
            chk_gap     <= (blank && !chk_blank_d) ? CKW'(1) : chk_gap + 1'b1;
            chk_blank_d <= blank;
            chk_seen    <= chk_seen | blank;
        end
    end

    // R3: each blanking run is exactly BLANK_CYCLES long
    p_width_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(blank) |-> (chk_low_run == CKW'(BLANK_CYCLES)));

    // R2 / R4: spacing of window starts
    p_period_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(blank) |-> (chk_gap == (chk_seen ? CKW'(FRAME_CYCLES) : CKW'(ACTIVE_CYCLES))));

endmodule

// File: rtl/vbl_accept.sv
module vbl_accept
    import vbl_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic window,
    input  logic irq_en,
    input  logic insn_boundary,
    output logic taken
);
    accept_state_t state_q, state_d;
    logic          hit;
    logic          take_now;
    logic          taken_q;

    assign hit = window && irq_en && insn_boundary;

    // next-state logic
    always_comb begin
        state_d  = state_q;
        take_now = 1'b0;
        unique case (state_q)
            ACC_IDLE: begin
                if (hit) begin
                    state_d  = ACC_HELD;
                    take_now = 1'b1;
                end else if (window) begin
                    state_d  = ACC_OPEN;
                end
            end
            ACC_OPEN: begin
                if (!window) begin
                    state_d = ACC_IDLE;
                end else if (hit) begin
                    state_d  = ACC_HELD;
                    take_now = 1'b1;
                end
            end
            ACC_HELD: begin
                if (!window) begin
                    state_d = ACC_IDLE;
                end
            end
            default: begin
                state_d = ACC_IDLE;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ACC_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // registered strobe output
    always_ff @(posedge clk) begin
        if (rst) begin
            taken_q <= 1'b0;
        end else begin
            taken_q <= take_now;
        end
    end

    assign taken = taken_q;

    // ---------------- checks ----------------
    logic [1:0] chk_taken_cnt;
    logic       chk_win_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            chk_taken_cnt <= '0;
            chk_win_d     <= 1'b0;
        end else begin
            chk_win_d <= window;
            if (window && !chk_win_d) begin
                chk_taken_cnt <= '0;
            end else if (taken && chk_taken_cnt != 2'd3) begin
                chk_taken_cnt <= chk_taken_cnt + 1'b1;
            end
        end
    end

    // R6: strobe lasts one cycle
    p_single_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        taken |=> !taken);

    // R6: strobe only follows a qualified sample
    p_qualified_r6: assert property (@(posedge clk) disable iff (rst)
        taken |-> $past(window && irq_en && insn_boundary));

    // R7: nothing delivered outside the window
    p_no_latch_r7: assert property (@(posedge clk) disable iff (rst)
        (!window && !$past(window)) |-> !taken);

    // R8: at most one acceptance per window
    p_once_per_window_r8: assert property (@(posedge clk) disable iff (rst)
        chk_taken_cnt <= 2'd1);

endmodule

// File: rtl/vblank_irq_gen.sv
module vblank_irq_gen #(
    parameter int FRAME_CYCLES = 14934,
    parameter int BLANK_CYCLES = 3791
) (
    input  logic clk,
    input  logic rst,
    input  logic irq_en,
    input  logic insn_boundary,
    output logic vblank_n,
    output logic blank_access,
    output logic irq_taken
);
    logic blank;

    vbl_frame_timer #(
        .FRAME_CYCLES (FRAME_CYCLES),
        .BLANK_CYCLES (BLANK_CYCLES)
    ) timer_i (
        .clk   (clk),
        .rst   (rst),
        .blank (blank)
    );

    vbl_accept accept_i (
        .clk           (clk),
        .rst           (rst),
        .window        (blank),
        .irq_en        (irq_en),
        .insn_boundary (insn_boundary),
        .taken         (irq_taken)
    );

    assign vblank_n     = ~blank;
    assign blank_access = blank;

    // R1: the line is released during reset
    p_line_idle_in_reset_r1: assert property (@(posedge clk)
        $past(rst) |-> vblank_n);

endmodule

// File: tb/vblank_irq_gen_tb.sv
`timescale 1ns/1ps
module vblank_irq_gen_tb_top;
    localparam int P   = 14934;
    localparam int W   = 3791;
    localparam int ACT = P - W;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic irq_en = 1'b0;
    logic insn_boundary = 1'b0;
    logic vblank_n, blank_access, irq_taken;

    always #4 clk = ~clk;

    vblank_irq_gen #(.FRAME_CYCLES(P), .BLANK_CYCLES(W)) dut_i (
        .clk           (clk),
        .rst           (rst),
        .irq_en        (irq_en),
        .insn_boundary (insn_boundary),
        .vblank_n      (vblank_n),
        .blank_access  (blank_access),
        .irq_taken     (irq_taken)
    );

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    function automatic bit exp_low(input int tt);
        return (tt % P) >= ACT;
    endfunction

    // ---------------- reference model ----------------
    int t = 0;
    bit m_got = 1'b0;
    bit exp_taken = 1'b0;
    bit model_on = 1'b0;

    always @(posedge clk) begin
        model_on = 1'b1;
        if (rst) begin
            t = 0;
            m_got = 1'b0;
            exp_taken = 1'b0;
        end else begin
            if (exp_low(t) && irq_en && insn_boundary && !m_got) begin
                exp_taken = 1'b1;
                m_got = 1'b1;
            end else begin
                exp_taken = 1'b0;
            end
            if (!exp_low(t)) m_got = 1'b0;
            t++;
        end
    end

    // ---------------- stimulus pattern per frame ----------------
    always @(posedge clk) begin
        #1;
        begin
            int ph;
            int f;
            ph = t % P;
            f  = t / P;
            case (f)
                0, 6: begin irq_en = 1'b1; insn_boundary = (ph % 97 == 0); end
                1:    begin irq_en = 1'b0; insn_boundary = (ph % 5 == 0); end
                2:    begin irq_en = 1'b1; insn_boundary = 1'b0; end
                3:    begin irq_en = 1'b1;
                            insn_boundary = (ph < ACT) ? (ph % 50 == 0) : (ph == P - 1); end
                4:    begin irq_en = 1'b1; insn_boundary = (ph == ACT); end
                5:    begin irq_en = ph[0]; insn_boundary = (ph % 3 == 0); end
                default: begin irq_en = 1'b0; insn_boundary = 1'b0; end
            endcase
        end
    end

    // ---------------- per-cycle compare and measurement ----------------
    int  seg = 1;
    int  win_idx = 0;
    int  tk_count [8];
    bit  prev_low = 1'b0;
    bit  fall_seen = 1'b0;
    int  last_fall_t = 0;
    int  run = 0;

    initial for (int i = 0; i < 8; i++) tk_count[i] = 0;

    always @(negedge clk) begin
        if (model_on) begin
            check(vblank_n == !exp_low(t), "R1", "vblank_n level", vblank_n, !exp_low(t));
            check(blank_access == exp_low(t), "R5", "blank_access level", blank_access, exp_low(t));
            check(irq_taken == exp_taken, "R6", "irq_taken", irq_taken, exp_taken);
            if (rst) begin
                prev_low  = 1'b0;
                fall_seen = 1'b0;
                run       = 0;
            end else begin
                if (!vblank_n && !prev_low) begin
                    if (!fall_seen) begin
                        check(t == ACT, "R4", "edges to first assertion", t, ACT);
                    end else begin
                        check(t - last_fall_t == P, "R2", "assertion spacing", t - last_fall_t, P);
                    end
                    fall_seen   = 1'b1;
                    last_fall_t = t;
                    run         = 1;
                    if (seg == 1) win_idx++;
                end else if (!vblank_n && prev_low) begin
                    run++;
                end else if (vblank_n && prev_low) begin
                    check(run == W, "R3", "assertion width", run, W);
                end
                if (irq_taken && seg == 1 && win_idx > 0 && win_idx <= 8)
                    tk_count[win_idx - 1]++;
                prev_low = !vblank_n;
            end
        end
    end

    // ---------------- sequence ----------------
    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(vblank_n == 1'b1 && blank_access == 1'b0 && irq_taken == 1'b0,
              "R9", "outputs in reset", {vblank_n, blank_access, irq_taken}, 3'b100);
        @(posedge clk);
        #1 rst = 1'b0;

        while (t < 7 * P + ACT + 200) @(negedge clk);
        // window results: R8 many boundaries, R7 enable clear, R7 no boundary,
        // R6 last cycle, R6 first cycle, R6 toggling enable, R8 again
        check(tk_count[0] == 1, "R8", "takes in window 0", tk_count[0], 1);
        check(tk_count[1] == 0, "R7", "takes in window 1 (enable clear)", tk_count[1], 0);
        check(tk_count[2] == 0, "R7", "takes in window 2 (no boundary)", tk_count[2], 0);
        check(tk_count[3] == 1, "R6", "takes in window 3 (last cycle)", tk_count[3], 1);
        check(tk_count[4] == 1, "R6", "takes in window 4 (first cycle)", tk_count[4], 1);
        check(tk_count[5] == 1, "R6", "takes in window 5", tk_count[5], 1);
        check(tk_count[6] == 1, "R8", "takes in window 6", tk_count[6], 1);
        check(vblank_n == 1'b0, "R1", "mid-window before reset", vblank_n, 0);

        seg = 2;
        @(posedge clk);
        #1 rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(vblank_n == 1'b1 && blank_access == 1'b0 && irq_taken == 1'b0,
              "R9", "outputs after mid-window reset", {vblank_n, blank_access, irq_taken}, 3'b100);
        @(posedge clk);
        #1 rst = 1'b0;
        repeat (ACT + W + 20) @(posedge clk);
        @(negedge clk);
        check(fall_seen == 1'b1, "R9", "timing restarted after reset", fall_seen, 1);
        finish_run();
    end

    initial begin
        #(190000 * 8);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule